// File: doc/BRIEF.md
# Block-Mode Serial Output-Enable Controller

This block is the control slave for a clock fanout device. It sits on a two-wire serial bus that runs in standard mode. The bus pins reach it as oversampled levels on the system clock. It holds the enable bits for twelve differential output pairs and one drive-strength select bit. Software reaches these bits only by block transfers, and every transfer walks the registers in order from index 0. No register address is ever sent.

A write starts with the write address byte. Two more bytes follow: a command byte and a byte-count byte. The slave acknowledges both and does not use them. Each later data byte lands in the next register index. A read starts with the read address byte. The slave first returns a fixed byte count and then the register bytes, index 0 first. The output-pair enables and the drive select come straight from the registers. An active-low power-down pin overrides them and puts every output pair in high impedance.

The bus interface is a plain open-drain pin pair. It has no valid/ready stream, so no back-pressure rules apply. A bus master paces every transfer through the clock line, and the slave never stretches that clock.

Top module: `i2cb_oe_ctrl`

## Requirements
- R1: After reset, all twelve pair enables read 1 and the drive-boost select reads 0. Index 6 reads back 0x8F and index 7 reads back 0xFF.
- R2: The slave acknowledges the address byte only when its upper seven bits equal 0x69, that is 0xD2 for a write and 0xD3 for a read. Any other address gets no acknowledge, and the rest of that transfer has no effect.
- R3: In a write, the two bytes that follow the address are acknowledged and discarded.
- R4: Each data byte in a write is acknowledged and stored at the next index, counting up from 0. The new value reaches the outputs within a few clocks after that byte's acknowledge slot begins.
- R5: In a read, the first byte returned is the byte count 0x09. The register bytes follow from index 0 upward, each sent most significant bit first.
- R6: Indices 0 to 5 and all indices above 7 read as 0x00. Writes to these indices are acknowledged and change nothing.
- R7: Bit n of index 7 enables pair n, for n from 0 to 7. Bits 3 to 0 of index 6 enable pairs 11 to 8, with bit 3 driving pair 11. Bit 5 of index 6 selects boosted drive. Bits 7, 6 and 4 of index 6 always read 1, 0 and 0.
- R8: While pd_n is low, pair_drive is all zero and pair_hiz is 1. The register contents are kept, and when pd_n returns high the outputs follow them again.
- R9: The slave starts pulling SDA low only while SCL is low.
- R10: A START or repeated START restarts address reception. A STOP releases SDA and returns the slave to idle. If the master does not acknowledge a read byte, the slave stops driving for the rest of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (open drain) |
| pd_n | input | 1 | Active-low power-down |
| pair_drive | output | 12 | Per pair: 1 when the pair drives its clock |
| pair_hiz | output | 1 | 1 when all output pairs are in high impedance |
| drive_boost | output | 1 | Boosted-drive select |

## Verification
The bench writes runs of random length. Some stop short of index 6, and some run past index 7. A slave that mis-counted the two discarded header bytes would shift every value into the wrong index. A slave that wrapped its position counter would overwrite the live registers with trailing bytes. The bench sends a foreign address and checks for a missing acknowledge. It also restarts the bus in the middle of a write, so a slave that kept its old byte position would return misplaced data. It ends a read early with a not-acknowledge and then checks that SDA is released, and it writes during power-down to check that the register contents are kept but not driven.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
package i2cb_pkg;
  typedef enum logic [1:0] {XF_IDLE, XF_ADDR, XF_WRITE, XF_READ} xfer_e;
  localparam int BYTE_W = 8;
  localparam int LO_BANK_PAIRS = 8;
endpackage

// File: rtl/i2cb_line_sync.sv
`timescale 1ns/1ps
module i2cb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES:0] scl_p, sda_p;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_now   = scl_p[STAGES-1];
  assign scl_old   = scl_p[STAGES];
  assign sda_s     = sda_p[STAGES-1];
  assign sda_old   = sda_p[STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign bus_start = scl_now & scl_old & sda_old & ~sda_s;
  assign bus_stop  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2cb_engine.sv
`timescale 1ns/1ps
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] COUNT_VAL = 8'h09,
  parameter int         IDX_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  xfer_e             mode;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  pos;
  logic [BYTE_W-1:0] tx_next;

  function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign tx_next = (pos == '0) ? COUNT_VAL : rd_data;
  assign rd_idx  = pos - 1'b1;
  assign wr_idx  = pos - IDX_W'(2);
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= XF_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      pos     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        mode    <= XF_ADDR;
        bit_cnt <= '0;
        pos     <= '0;
        sda_oe  <= 1'b0;
      end else if (bus_stop) begin
        mode    <= XF_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (mode != XF_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < LAST_BIT) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (mode != XF_READ) shreg <= {shreg[BYTE_W-2:0], sda_s};
          end else if (bit_cnt == ACK_SLOT && mode == XF_READ && sda_s) begin
            mode <= XF_IDLE;
          end
        end else if (scl_fall) begin
          if (bit_cnt == LAST_BIT) begin
            bit_cnt <= ACK_SLOT;
            case (mode)
              XF_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) sda_oe <= 1'b1;
                else                        mode   <= XF_IDLE;
              end
              XF_WRITE: begin
                sda_oe <= 1'b1;
                if (pos >= IDX_W'(2)) wr_en <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bit_cnt == ACK_SLOT) begin
            bit_cnt <= '0;
            case (mode)
              XF_ADDR: begin
                if (shreg[0]) begin
                  mode   <= XF_READ;
                  shreg  <= tx_next;
                  sda_oe <= ~tx_next[BYTE_W-1];
                  pos    <= sat_inc(pos);
                end else begin
                  mode   <= XF_WRITE;
                  sda_oe <= 1'b0;
                end
              end
              XF_WRITE: begin
                sda_oe <= 1'b0;
                pos    <= sat_inc(pos);
              end
              default: begin
                shreg  <= tx_next;
                sda_oe <= ~tx_next[BYTE_W-1];
                pos    <= sat_inc(pos);
              end
            endcase
          end else if (mode == XF_READ && bit_cnt != '0) begin
            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
            sda_oe <= ~shreg[BYTE_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cb_regs.sv
`timescale 1ns/1ps
module i2cb_regs
  import i2cb_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int NUM_PAIRS = 12,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [BYTE_W-1:0]    rd_data,
  output logic [NUM_PAIRS-1:0] pair_en,
  output logic                 boost
);
  localparam int               HI_EN_W  = NUM_PAIRS - LO_BANK_PAIRS;
  localparam logic [IDX_W-1:0] HI_IDX   = IDX_W'(NUM_REGS - 2);
  localparam logic [IDX_W-1:0] LO_IDX   = IDX_W'(NUM_REGS - 1);
  localparam logic [7:0]       HI_FIXED = 8'h80;
  localparam int               BOOST_B  = 5;

  logic [LO_BANK_PAIRS-1:0] lo_q;
  logic [HI_EN_W-1:0]       hi_en_q;
  logic                     boost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '1;
      hi_en_q <= '1;
      boost_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_idx == LO_IDX) lo_q <= wr_data;
      if (wr_idx == HI_IDX) begin
        hi_en_q <= wr_data[HI_EN_W-1:0];
        boost_q <= wr_data[BOOST_B];
      end
    end
  end

  always_comb begin
    if (rd_idx == LO_IDX)
      rd_data = lo_q;
    else if (rd_idx == HI_IDX)
      rd_data = HI_FIXED | (8'(boost_q) << BOOST_B) | 8'(hi_en_q);
    else
      rd_data = '0;
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    if (g < LO_BANK_PAIRS) begin : g_lo
      assign pair_en[g] = lo_q[g];
    end else begin : g_hi
      assign pair_en[g] = hi_en_q[g-LO_BANK_PAIRS];
    end
  end

  assign boost = boost_q;
endmodule

// File: rtl/i2cb_oe_ctrl.sv
`timescale 1ns/1ps
module i2cb_oe_ctrl
  import i2cb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] COUNT_VAL   = 8'h09,
  parameter int         NUM_REGS    = 8,
  parameter int         NUM_PAIRS   = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic                 pd_n,
  output logic [NUM_PAIRS-1:0] pair_drive,
  output logic                 pair_hiz,
  output logic                 drive_boost
);
  localparam int IDX_W = $clog2(NUM_REGS) + 1;

  logic                 sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic                 wr_en;
  logic [IDX_W-1:0]     wr_idx, rd_idx;
  logic [BYTE_W-1:0]    wr_data, rd_data;
  logic [NUM_PAIRS-1:0] pair_en;

  i2cb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2cb_engine #(.DEV_ADDR(DEV_ADDR), .COUNT_VAL(COUNT_VAL), .IDX_W(IDX_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .bus_start(bus_start), .bus_stop(bus_stop),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  i2cb_regs #(.NUM_REGS(NUM_REGS), .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .pair_en(pair_en), .boost(drive_boost)
  );

  assign pair_drive = pair_en & {NUM_PAIRS{pd_n}};
  assign pair_hiz   = ~pd_n;
endmodule

// File: rtl/i2cb_oe_ctrl_chk.sv
`timescale 1ns/1ps
module i2cb_oe_ctrl_chk #(
  parameter int NUM_PAIRS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pd_n,
  input logic                 sda_oe,
  input logic [NUM_PAIRS-1:0] pair_drive,
  input logic                 pair_hiz,
  input logic                 drive_boost,
  input logic [NUM_PAIRS-1:0] pair_en,
  input logic                 scl_fall,
  input logic                 bus_stop
);
  // R8: power-down overrides every enable
  p_pd_forces_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (pair_drive == '0 && pair_hiz));

  // R9: a new pull on SDA begins only after SCL has been seen falling
  p_sda_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R10: a STOP releases the data line
  p_stop_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);

  // R4: register state moves only right after the slave starts an acknowledge
  p_update_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(pair_en) || $changed(drive_boost)) |-> ($past(sda_oe) && !$past(sda_oe, 2)));
endmodule

bind i2cb_oe_ctrl i2cb_oe_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .sda_oe(sda_oe),
  .pair_drive(pair_drive), .pair_hiz(pair_hiz), .drive_boost(drive_boost),
  .pair_en(pair_en), .scl_fall(scl_fall), .bus_stop(bus_stop)
);

// File: tb/i2cb_oe_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2cb_oe_ctrl_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pd_n = 1'b1;
  logic sda_oe, pair_hiz, drive_boost;
  logic [11:0] pair_drive;
  logic sda_bus;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] m6 = 8'h8F;
  logic [7:0] m7 = 8'hFF;
  logic [7:0] wbuf [16];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2cb_oe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pd_n(pd_n), .pair_drive(pair_drive), .pair_hiz(pair_hiz), .drive_boost(drive_boost)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input int idx);
    if (idx == 6) return m6;
    if (idx == 7) return m7;
    return 8'h00;
  endfunction

  function automatic logic [11:0] exp_pairs();
    return {m6[3:0], m7};
  endfunction

  task automatic model_write(input int d, input logic [7:0] v);
    if (d == 6) m6 = (v & 8'h2F) | 8'h80;
    if (d == 7) m7 = v;
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = !sda_bus;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic check_outputs(input string tag);
    wq(4);
    chk(pair_drive == (pd_n ? exp_pairs() : 12'h000), tag, pair_drive, pd_n ? exp_pairs() : 12'h000);
    chk(drive_boost == m6[5], {tag, " boost"}, drive_boost, m6[5]);
    chk(pair_hiz == !pd_n, {tag, " hiz"}, pair_hiz, !pd_n);
  endtask

  // Write header plus n data bytes, starting at index 0.
  task automatic do_write(input int n, input bit end_with_stop);
    bit ack;
    bus_start();
    wbyte(8'hD2, ack);                 chk(ack, "R2 write address ack", ack, 1);
    wbyte(8'($urandom), ack);          chk(ack, "R3 command byte ack", ack, 1);
    wbyte(8'($urandom), ack);          chk(ack, "R3 count byte ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ack);
      chk(ack, (i > 7) ? "R6 byte past last index ack" : "R4 data byte ack", ack, 1);
      model_write(i, wbuf[i]);
    end
    if (end_with_stop) bus_stop();
  endtask

  // Read count plus n data bytes; start_kind 0 = fresh START, 1 = repeated START.
  task automatic do_read(input int n, input bit restart);
    bit ack;
    logic [7:0] v;
    if (restart) bus_restart(); else bus_start();
    wbyte(8'hD3, ack);                 chk(ack, "R2 read address ack", ack, 1);
    rbyte(n > 0, v);                   chk(v == 8'h09, "R5 byte count", v, 8'h09);
    for (int i = 0; i < n; i++) begin
      rbyte(i < n - 1, v);
      chk(v == exp_read(i), (i == 6 || i == 7) ? "R5 register readback" : "R6 unused index reads zero",
          v, exp_read(i));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    void'($urandom(32'd2024));
    wq(5); rst_n = 1'b1; wq(5);

    // R1 reset state
    check_outputs("R1 reset enables");
    chk(sda_bus == 1'b1, "R1 bus released", sda_bus, 1);
    do_read(9, 1'b0);

    // R2 foreign addresses are not acknowledged and write nothing
    bus_start();
    wbyte(8'hA0, ack);                 chk(!ack, "R2 foreign address", ack, 0);
    for (int i = 0; i < 9; i++) wbyte(8'h00, ack);
    bus_stop();
    bus_start();
    wbyte(8'hD0, ack);                 chk(!ack, "R2 neighbour address", ack, 0);
    bus_stop();
    check_outputs("R2 no effect");

    // R3/R4/R7 directed write, pair 11 off, boost on, reserved bits set
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hFF;
    wbuf[6] = 8'hF7; wbuf[7] = 8'h5A;
    do_write(8, 1'b1);
    check_outputs("R7 pair map");
    chk(m6 == 8'hA7, "R7 reserved bits fixed", m6, 8'hA7);
    do_read(8, 1'b0);

    // R6 bytes beyond index 7 are discarded
    wbuf[6] = 8'h20; wbuf[7] = 8'h81; wbuf[8] = 8'h00; wbuf[9] = 8'h00; wbuf[10] = 8'h00;
    do_write(11, 1'b1);
    check_outputs("R6 trailing bytes discarded");

    // R10 repeated START in the middle of a write, then read back
    wbuf[6] = 8'h0C;
    do_write(7, 1'b0);
    do_read(9, 1'b1);
    check_outputs("R10 restart keeps partial write");

    // R10 master NACK on the count byte releases SDA
    bus_start();
    wbyte(8'hD3, ack);                 chk(ack, "R2 read address ack", ack, 1);
    rbyte(1'b0, v);                    chk(v == 8'h09, "R5 count before nack", v, 8'h09);
    wq(Q); scl_m = 1'b1; wq(Q);
    chk(sda_bus == 1'b1, "R10 released after nack", sda_bus, 1);
    scl_m = 1'b0; wq(Q);
    bus_stop();
    do_read(9, 1'b0);

    // R8 power-down
    pd_n = 1'b0;
    check_outputs("R8 power-down");
    wbuf[6] = 8'h2F; wbuf[7] = 8'h3C;
    do_write(8, 1'b1);
    check_outputs("R8 write during power-down");
    pd_n = 1'b1;
    check_outputs("R8 contents kept");

    // Random block writes of varied length, each read back
    for (int it = 0; it < 12; it++) begin
      int n;
      n = $urandom_range(0, 11);
      for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
      do_write(n, 1'b1);
      check_outputs("R4 random write");
      do_read(9, 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule